// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block gates the supply of one switchable logic domain. Software programs a single 32-bit control and status word. A hardware state machine then powers the domain up or down in a fixed order. Power-up closes a small group of header switches first, which limits inrush current. It then closes the remaining switches, releases the isolation clamp and the domain reset, and finally opens the clock gate. Power-down reverses this order.

Each switch stage and the clock-off step wait a programmable 2^n reference-clock cycles. The power request can come from three places:
- a register bit;
- an external request line, which passes through a synchronizer;
- a software override that drives the domain controls directly and skips every wait.

A status bit reports a fully powered domain.

Top module: `pdom_seq`

## Requirements
- R1: After reset the control word reads 0x0000_0001. Both switch groups are open, the clamp is asserted, the domain reset is asserted (dom_rst_n = 0), the clock gate is closed, and pwr_ok is 0.
- R2: Only bit 0 (collapse request), bit 1 (hardware mode), bit 2 (override), bits [23:20] (rest-stage exponent), bits [19:16] (few-stage exponent) and bits [15:12] (clock-off exponent) are writable. All other bits read 0, except bit 31, which reads pwr_ok and ignores writes.
- R3: When the register write clearing bit 0 lands at clock edge k, the few switches alone are closed from edge k+1 for 2^nf cycles. Both groups are then closed with the clamp and reset held for 2^nr cycles. Then follows one cycle with the clamp and reset released and the clock still gated. After that the clock is enabled and pwr_ok is 1.
- R4: When the write setting bit 0 lands at edge j, pwr_ok and the clock drop at edge j+1. The switches stay closed and the clamp released for 2^nc cycles. Then follows one cycle with the clamp and reset asserted and the switches still closed. After that both groups open.
- R5: A request change during a sequence does not disturb it. The sequence completes to its stable state, and only then is the new request acted on.
- R6: With bit 1 set, the request follows hw_collapse_req (1 = collapse) after a SYNC_STAGES-cycle synchronizer, and bit 0 is ignored. With bit 1 clear, hw_collapse_req has no effect.
- R7: With bit 2 set, the outputs follow the effective request in the same cycle the register changes, with no waits. Collapse gives the fully off pattern; power-up gives the fully on pattern with pwr_ok = 1.
- R8: Clearing bit 2 while the request is unchanged leaves every output unchanged.
- R9: The clock is enabled only with both groups closed, the clamp released and the reset released. The rest group closes only with the few group closed. The clamp is released only with both groups closed.
- R10: A wait exponent of 0 gives a one-cycle stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write data |
| csr_rdata | output | 32 | Control word read value, status in bit 31 |
| hw_collapse_req | input | 1 | External request, 1 asks for power-down |
| sw_few_en | output | 1 | Closes the first, small switch group |
| sw_rest_en | output | 1 | Closes the remaining switch group |
| clamp_en | output | 1 | Isolation clamp on the domain outputs |
| dom_rst_n | output | 1 | Active-low reset to the domain |
| clk_en | output | 1 | Clock gate enable for the domain |
| pwr_ok | output | 1 | Domain fully powered |

## Verification
A state machine stuck in, or skipping, a wait stage shows at the switch and clamp pins within one cycle of the expected boundary. For that reason every power sequence is compared against its expected output pattern on every cycle, not just at its end. A wrongly decoded state appears as an illegal combination of pins, such as the clock enabled with the clamp asserted, on the very cycle that state is entered. A lost or double-latched request appears as a missing or repeated sequence on the cycle after the stable state is reached.

// File: rtl/pdom_seq_pkg.sv
package pdom_seq_pkg;

   localparam int unsigned COLLAPSE_BIT = 0;
   localparam int unsigned HWMODE_BIT   = 1;
   localparam int unsigned OVR_BIT      = 2;
   localparam int unsigned CDIS_LSB     = 12;
   localparam int unsigned FEW_LSB      = 16;
   localparam int unsigned REST_LSB     = 20;
   localparam int unsigned STATUS_BIT   = 31;
   localparam int unsigned FIELD_W      = 4;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_FEW,
      ST_REST,
      ST_UNCLAMP,
      ST_ON,
      ST_CLKOFF,
      ST_CLAMP
   } pd_state_e;

   typedef struct packed {
      logic few;
      logic rest;
      logic clamp;
      logic rst_n;
      logic clk;
      logic ok;
   } pd_ctl_t;

   typedef struct packed {
      logic               collapse;
      logic               hw_mode;
      logic               ovr;
      logic [FIELD_W-1:0] w_rest;
      logic [FIELD_W-1:0] w_few;
      logic [FIELD_W-1:0] w_cdis;
   } pd_cfg_t;

   localparam pd_ctl_t CTL_OFF = '{few:1'b0, rest:1'b0, clamp:1'b1, rst_n:1'b0, clk:1'b0, ok:1'b0};
   localparam pd_ctl_t CTL_ON  = '{few:1'b1, rest:1'b1, clamp:1'b0, rst_n:1'b1, clk:1'b1, ok:1'b1};

endpackage

// File: rtl/pdom_seq_csr.sv
module pdom_seq_csr
   import pdom_seq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              status,
   output logic [DATA_W-1:0] rdata,
   output pd_cfg_t           cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.collapse <= 1'b1;
         cfg.hw_mode  <= 1'b0;
         cfg.ovr      <= 1'b0;
         cfg.w_rest   <= '0;
         cfg.w_few    <= '0;
         cfg.w_cdis   <= '0;
      end else if (we) begin
         cfg.collapse <= wdata[COLLAPSE_BIT];
         cfg.hw_mode  <= wdata[HWMODE_BIT];
         cfg.ovr      <= wdata[OVR_BIT];
         cfg.w_rest   <= wdata[REST_LSB +: FIELD_W];
         cfg.w_few    <= wdata[FEW_LSB  +: FIELD_W];
         cfg.w_cdis   <= wdata[CDIS_LSB +: FIELD_W];
      end
   end

   always_comb begin
      rdata                        = '0;
      rdata[COLLAPSE_BIT]          = cfg.collapse;
      rdata[HWMODE_BIT]            = cfg.hw_mode;
      rdata[OVR_BIT]               = cfg.ovr;
      rdata[REST_LSB +: FIELD_W]   = cfg.w_rest;
      rdata[FEW_LSB  +: FIELD_W]   = cfg.w_few;
      rdata[CDIS_LSB +: FIELD_W]   = cfg.w_cdis;
      rdata[STATUS_BIT]            = status;
   end

endmodule

// File: rtl/pdom_seq_sync.sv
module pdom_seq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else        sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pdom_seq_timer.sv
module pdom_seq_timer #(
   parameter int unsigned EXP_W   = 4,
   parameter int unsigned MAX_EXP = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [EXP_W-1:0] exp_n,
   output logic             done
);

   localparam int unsigned CNT_W = MAX_EXP + 1;

   logic [CNT_W-1:0] cnt;
   logic [EXP_W-1:0] exp_clip;

   assign exp_clip = (exp_n > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= (CNT_W'(1) << exp_clip) - CNT_W'(1);
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/pdom_seq_fsm.sv
module pdom_seq_fsm
   import pdom_seq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_collapse,
   input  logic               ovr,
   input  pd_cfg_t            cfg,
   input  logic               wait_done,
   output logic               wait_load,
   output logic [FIELD_W-1:0] wait_exp,
   output pd_state_e          state
);

   pd_state_e nxt;

   always_comb begin
      nxt       = state;
      wait_load = 1'b0;
      wait_exp  = '0;
      unique case (state)
         ST_OFF: if (!req_collapse) begin
            nxt = ST_FEW;  wait_load = 1'b1; wait_exp = cfg.w_few;
         end
         ST_FEW: if (wait_done) begin
            nxt = ST_REST; wait_load = 1'b1; wait_exp = cfg.w_rest;
         end
         ST_REST:    if (wait_done) nxt = ST_UNCLAMP;
         ST_UNCLAMP: nxt = ST_ON;
         ST_ON: if (req_collapse) begin
            nxt = ST_CLKOFF; wait_load = 1'b1; wait_exp = cfg.w_cdis;
         end
         ST_CLKOFF:  if (wait_done) nxt = ST_CLAMP;
         ST_CLAMP:   nxt = ST_OFF;
         default:    nxt = ST_OFF;
      endcase
      if (ovr) begin
         nxt       = req_collapse ? ST_OFF : ST_ON;
         wait_load = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OFF;
      else        state <= nxt;
   end

endmodule

// File: rtl/pdom_seq.sv
module pdom_seq
   import pdom_seq_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MAX_EXP     = 15,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              hw_collapse_req,
   output logic              sw_few_en,
   output logic              sw_rest_en,
   output logic              clamp_en,
   output logic              dom_rst_n,
   output logic              clk_en,
   output logic              pwr_ok
);

   if (DATA_W != 32) begin : g_bad_width
      $error("pdom_seq: DATA_W must be 32, field positions are fixed");
   end
   if (MAX_EXP < 1 || MAX_EXP > 15) begin : g_bad_exp
      $error("pdom_seq: MAX_EXP must lie in 1..15");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("pdom_seq: SYNC_STAGES must not exceed 4");
   end

   pd_cfg_t            cfg;
   pd_state_e          state;
   pd_ctl_t            seq_ctl, ovr_ctl, ctl;
   logic               hw_req_s, req_eff;
   logic               wait_load, wait_done;
   logic [FIELD_W-1:0] wait_exp;

   pdom_seq_csr #(.DATA_W(DATA_W)) u_csr (
      .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
      .status(ctl.ok), .rdata(csr_rdata), .cfg(cfg)
   );

   pdom_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(hw_collapse_req), .q(hw_req_s)
   );

   assign req_eff = cfg.hw_mode ? hw_req_s : cfg.collapse;

   pdom_seq_timer #(.EXP_W(FIELD_W), .MAX_EXP(MAX_EXP)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(wait_load), .exp_n(wait_exp), .done(wait_done)
   );

   pdom_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_collapse(req_eff), .ovr(cfg.ovr),
      .cfg(cfg), .wait_done(wait_done), .wait_load(wait_load),
      .wait_exp(wait_exp), .state(state)
   );

   always_comb begin
      seq_ctl = CTL_OFF;
      unique case (state)
         ST_FEW:     seq_ctl = '{few:1'b1, rest:1'b0, clamp:1'b1, rst_n:1'b0, clk:1'b0, ok:1'b0};
         ST_REST:    seq_ctl = '{few:1'b1, rest:1'b1, clamp:1'b1, rst_n:1'b0, clk:1'b0, ok:1'b0};
         ST_UNCLAMP: seq_ctl = '{few:1'b1, rest:1'b1, clamp:1'b0, rst_n:1'b1, clk:1'b0, ok:1'b0};
         ST_ON:      seq_ctl = CTL_ON;
         ST_CLKOFF:  seq_ctl = '{few:1'b1, rest:1'b1, clamp:1'b0, rst_n:1'b1, clk:1'b0, ok:1'b0};
         ST_CLAMP:   seq_ctl = '{few:1'b1, rest:1'b1, clamp:1'b1, rst_n:1'b0, clk:1'b0, ok:1'b0};
         default:    seq_ctl = CTL_OFF;
      endcase
   end

   assign ovr_ctl = req_eff ? CTL_OFF : CTL_ON;
   assign ctl     = cfg.ovr ? ovr_ctl : seq_ctl;

   assign sw_few_en  = ctl.few;
   assign sw_rest_en = ctl.rest;
   assign clamp_en   = ctl.clamp;
   assign dom_rst_n  = ctl.rst_n;
   assign clk_en     = ctl.clk;
   assign pwr_ok     = ctl.ok;

endmodule

// File: rtl/pdom_seq_chk.sv
module pdom_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] csr_rdata,
   input logic        sw_few_en,
   input logic        sw_rest_en,
   input logic        clamp_en,
   input logic        dom_rst_n,
   input logic        clk_en,
   input logic        pwr_ok
);

   logic ovr;
   assign ovr = csr_rdata[2];

   a_r9_clk_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> (sw_few_en && sw_rest_en && !clamp_en && dom_rst_n));

   a_r9_rest_after_few: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rest_en |-> sw_few_en);

   a_r9_unclamp_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      !clamp_en |-> (sw_few_en && sw_rest_en));

   a_r3_status_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ok |-> clk_en);

   a_r3_few_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr && !$past(ovr) && $rose(sw_rest_en)) |-> $past(sw_few_en));

   a_r3_unclamp_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr && !$past(ovr) && $rose(clk_en)) |-> ($past(!clamp_en) && $past(dom_rst_n)));

   a_r4_clamp_before_open: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr && !$past(ovr) && $fell(sw_few_en)) |-> ($past(clamp_en) && !$past(dom_rst_n)));

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[30:24] == 7'd0) && (csr_rdata[11:3] == 9'd0));

   a_r2_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[31] == pwr_ok);

endmodule

bind pdom_seq pdom_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .csr_rdata(csr_rdata),
   .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en), .clamp_en(clamp_en),
   .dom_rst_n(dom_rst_n), .clk_en(clk_en), .pwr_ok(pwr_ok)
);

// File: tb/pdom_seq_tb.sv
module pdom_seq_tb;

   localparam int WD_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        hw_collapse_req = 1'b1;
   logic        sw_few_en, sw_rest_en, clamp_en, dom_rst_n, clk_en, pwr_ok;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pdom_seq u_dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .hw_collapse_req(hw_collapse_req),
      .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en), .clamp_en(clamp_en),
      .dom_rst_n(dom_rst_n), .clk_en(clk_en), .pwr_ok(pwr_ok)
   );

   // expected pin patterns {few, rest, clamp, rst_n, clk, ok}
   localparam logic [5:0] P_OFF     = 6'b001000;
   localparam logic [5:0] P_FEW     = 6'b101000;
   localparam logic [5:0] P_REST    = 6'b111000;
   localparam logic [5:0] P_UNCLAMP = 6'b110100;
   localparam logic [5:0] P_ON      = 6'b110111;
   localparam logic [5:0] P_CLKOFF  = 6'b110100;
   localparam logic [5:0] P_CLAMP   = 6'b111000;

   function automatic logic [31:0] ctrl(bit ovr, bit hw, bit col,
                                        int nr, int nf, int nc);
      logic [31:0] w = '0;
      w[0] = col; w[1] = hw; w[2] = ovr;
      w[23:20] = nr[3:0]; w[19:16] = nf[3:0]; w[15:12] = nc[3:0];
      return w;
   endfunction

   task automatic chk_pins(input logic [5:0] exp, input string tag);
      logic [5:0] act;
      act = {sw_few_en, sw_rest_en, clamp_en, dom_rst_n, clk_en, pwr_ok};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s pins act=%b exp=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_word(input logic [31:0] exp, input string tag);
      checks++;
      if (csr_rdata !== exp) begin
         errors++;
         $display("FAIL %s rdata act=%h exp=%h", tag, csr_rdata, exp);
      end
   endtask

   // called at a negedge, returns at the negedge after the write edge
   task automatic wr(input logic [31:0] v);
      csr_we = 1'b1; csr_wdata = v;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic run(input logic [5:0] exp, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk_pins(exp, tag);
      end
   endtask

   task automatic power_up(input int nr, input int nf, input int nc, input string tag);
      wr(ctrl(0, 0, 0, nr, nf, nc));
      chk_pins(P_OFF, tag);
      run(P_FEW, 1 << nf, tag);
      run(P_REST, 1 << nr, tag);
      run(P_UNCLAMP, 1, tag);
      run(P_ON, 1, tag);
   endtask

   task automatic power_down(input int nr, input int nf, input int nc, input string tag);
      wr(ctrl(0, 0, 1, nr, nf, nc));
      chk_pins(P_ON, tag);
      run(P_CLKOFF, 1 << nc, tag);
      run(P_CLAMP, 1, tag);
      run(P_OFF, 1, tag);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      int nr, nf, nc;
      seed = $urandom(32'h5EED_0042);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_pins(P_OFF, "R1");
      chk_word(32'h0000_0001, "R1");

      // R2 writable mask, status bit write ignored
      wr(32'hFFFF_FFFF);
      chk_word(32'h00FF_F007, "R2");
      chk_pins(P_OFF, "R2");
      wr(32'h0000_0001);
      chk_word(32'h0000_0001, "R2");

      // R6 hardware line ignored when mode bit clear
      hw_collapse_req = 1'b0;
      run(P_OFF, 5, "R6_ignored");
      hw_collapse_req = 1'b1;
      run(P_OFF, 3, "R6_ignored");

      // R10 zero exponents, R3/R4 directed
      power_up(0, 0, 0, "R10_up");
      power_down(0, 0, 0, "R10_down");
      power_up(3, 1, 2, "R3");
      chk_word(32'h8031_2000, "R2_status");
      power_down(3, 1, 2, "R4");

      // random waits
      for (int it = 0; it < 8; it++) begin
         nr = int'($urandom_range(5, 0));
         nf = int'($urandom_range(5, 0));
         nc = int'($urandom_range(5, 0));
         power_up(nr, nf, nc, "R3_rand");
         power_down(nr, nf, nc, "R4_rand");
      end

      // R5 collapse asked during power-up
      wr(ctrl(0, 0, 0, 2, 2, 1));
      chk_pins(P_OFF, "R5");
      run(P_FEW, 1, "R5");
      wr(ctrl(0, 0, 1, 2, 2, 1));
      chk_pins(P_FEW, "R5");
      run(P_FEW, 2, "R5");
      run(P_REST, 4, "R5");
      run(P_UNCLAMP, 1, "R5");
      run(P_ON, 1, "R5");
      run(P_CLKOFF, 2, "R5");
      run(P_CLAMP, 1, "R5");
      run(P_OFF, 1, "R5");
      // R5 power-up asked during power-down
      power_up(0, 0, 2, "R5_pre");
      wr(ctrl(0, 0, 1, 0, 0, 2));
      chk_pins(P_ON, "R5");
      run(P_CLKOFF, 1, "R5");
      wr(ctrl(0, 0, 0, 0, 0, 2));
      chk_pins(P_CLKOFF, "R5");
      run(P_CLKOFF, 2, "R5");
      run(P_CLAMP, 1, "R5");
      run(P_OFF, 1, "R5");
      run(P_FEW, 1, "R5");
      run(P_REST, 1, "R5");
      run(P_UNCLAMP, 1, "R5");
      run(P_ON, 1, "R5");
      power_down(0, 0, 0, "R5_post");

      // R6 hardware trigger, two-stage synchronizer
      wr(ctrl(0, 1, 1, 0, 0, 0));
      chk_pins(P_OFF, "R6");
      hw_collapse_req = 1'b0;
      run(P_OFF, 2, "R6_sync");
      run(P_FEW, 1, "R6");
      run(P_REST, 1, "R6");
      run(P_UNCLAMP, 1, "R6");
      run(P_ON, 3, "R6_bit0_ignored");
      hw_collapse_req = 1'b1;
      run(P_ON, 2, "R6_sync");
      run(P_CLKOFF, 1, "R6");
      run(P_CLAMP, 1, "R6");
      run(P_OFF, 2, "R6");
      wr(ctrl(0, 0, 1, 0, 0, 0));

      // R7 override follows request at once
      wr(ctrl(1, 0, 0, 5, 5, 5));
      chk_pins(P_ON, "R7_on");
      chk_word(32'h8055_5004, "R7");
      wr(ctrl(1, 0, 1, 5, 5, 5));
      chk_pins(P_OFF, "R7_off");
      wr(ctrl(1, 0, 0, 5, 5, 5));
      chk_pins(P_ON, "R7_on");
      run(P_ON, 2, "R7");

      // R8 leave override without request change
      wr(ctrl(0, 0, 0, 5, 5, 0));
      chk_pins(P_ON, "R8");
      run(P_ON, 3, "R8");
      power_down(0, 0, 0, "R8_live");
      wr(ctrl(1, 0, 1, 0, 0, 0));
      chk_pins(P_OFF, "R8");
      wr(ctrl(0, 0, 1, 0, 0, 0));
      chk_pins(P_OFF, "R8");
      run(P_OFF, 3, "R8");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule